// File: doc/BRIEF.md
# Effective Address Unit

This unit resolves operand and jump addresses for an 8-bit processor with a 16-bit address space. It gets a mode code, the operand bytes that follow an opcode, the X and Y index registers, the stack pointer, the current program counter and a branch-taken bit. A one-cycle `start_i` pulse accepts these inputs. Direct modes produce their address one cycle later.

Indirect modes first read a two-byte pointer. The unit presents the address of the pointer's low byte and raises `ptr_rd_o`. The bus logic returns the byte with `ptr_valid_i`. The unit then asks for the high byte in the same way. When the result is ready, `done_o` pulses for one cycle, with these outputs:
- the effective address;
- a new program counter value, plus a load strobe for jumps and taken branches;
- a flag set when indexing or branching changed the high address byte.

Opcode decoding and any other bus sequencing are outside this unit.

Top module: `ea_unit`

## Requirements
- R1: After reset `done_o`, `ptr_rd_o`, `pc_load_o` and `page_cross_o` are all 0.
- R2: Mode 0 (absolute) raises `done_o` one cycle after the accepting edge, with `addr_o` = {op_hi_i, op_lo_i} and `page_cross_o` = 0.
- R3: Mode 1 (zero page) gives {00, op_lo}. Mode 2 gives {00, op_lo+X} and mode 3 gives {00, op_lo+Y}. In modes 2 and 3 the 8-bit sum wraps inside page zero.
- R4: Mode 6 (stack) gives {STACK_PAGE, sp_i}, where STACK_PAGE defaults to 01.
- R5: Mode 4 gives {op_hi, op_lo}+X and mode 5 gives {op_hi, op_lo}+Y. Both are 16-bit sums that wrap at FFFF. `page_cross_o` is 1 exactly when the high byte differs from op_hi.
- R6: Indirect modes (8 to 12) assert `ptr_rd_o` with `addr_o` on the pointer's low-byte location, and hold it until `ptr_valid_i`. They then do the same for low location + 1, and raise `done_o` in the cycle after the second valid. For zero-page pointers, + 1 wraps within page zero. For absolute pointers it carries across all 16 bits.
- R7: Mode 8 (zero-page indirect) reads its pointer at op_lo. Mode 9 reads it at op_lo+X, wrapped in page zero. In both, the effective address is the fetched pointer {high, low}.
- R8: Mode 10 reads its pointer at op_lo and adds Y with a full 16-bit carry. `page_cross_o` is 1 when the high byte differs from the pointer's high byte.
- R9: Mode 11 reads its pointer at {op_hi, op_lo}. Mode 12 reads it at {op_hi, op_lo}+X, and there `page_cross_o` flags that sum's high-byte change. Both drive `new_pc_o` with the fetched pointer and assert `pc_load_o` with `done_o`.
- R10: Mode 7 (relative) with `take_i`=1 sets `new_pc_o` = pc_i + sign-extended op_lo and asserts `pc_load_o`. `page_cross_o` shows a high-byte change. With `take_i`=0 it gives `new_pc_o` = pc_i, and `pc_load_o` and `page_cross_o` stay 0.
- R11: `start_i` has no effect while an operation is in flight.
- R12: `done_o` lasts exactly one cycle per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Accept the mode and operands |
| mode_i | input | 4 | Addressing mode code |
| op_lo_i | input | DW | First operand byte (also relative offset) |
| op_hi_i | input | DW | Second operand byte |
| x_i | input | DW | X index |
| y_i | input | DW | Y index |
| sp_i | input | DW | Stack pointer |
| pc_i | input | 2*DW | Program counter after the instruction |
| take_i | input | 1 | Branch condition met |
| ptr_data_i | input | DW | Pointer byte from memory |
| ptr_valid_i | input | 1 | Pointer byte is valid |
| addr_o | output | 2*DW | Pointer fetch address or effective address |
| ptr_rd_o | output | 1 | Pointer byte request |
| done_o | output | 1 | Result valid |
| new_pc_o | output | 2*DW | Program counter value for jumps and branches |
| pc_load_o | output | 1 | Load `new_pc_o` |
| page_cross_o | output | 1 | High address byte changed by indexing or branching |

## Verification
The bench uses the defaults DW=8 and STACK_PAGE=01. With these values the wrap points sit at zero-page FF and at address FFFF, where a short directed test can reach them. Several cases start at offsets FE and FF, so the zero-page pointer-high wrap and the 16-bit Y carry are both hit. A stalled pointer reply with a competing start pulse exercises the hold and ignore rules. Forward and backward branches cover the sign extension.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [3:0] {
    EA_ABS       = 4'd0,
    EA_ZP        = 4'd1,
    EA_ZP_X      = 4'd2,
    EA_ZP_Y      = 4'd3,
    EA_ABS_X     = 4'd4,
    EA_ABS_Y     = 4'd5,
    EA_STACK     = 4'd6,
    EA_REL       = 4'd7,
    EA_ZP_IND    = 4'd8,
    EA_ZP_X_IND  = 4'd9,
    EA_ZP_IND_Y  = 4'd10,
    EA_JMP_IND   = 4'd11,
    EA_JMP_X_IND = 4'd12
  } ea_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PLO,
    ST_PHI,
    ST_FIN
  } ea_state_e;

  function automatic logic is_indirect(input logic [3:0] m);
    return (m >= 4'd8) && (m <= 4'd12);
  endfunction

  function automatic logic is_zp_ptr(input logic [3:0] m);
    return (m == EA_ZP_IND) || (m == EA_ZP_X_IND) || (m == EA_ZP_IND_Y);
  endfunction
endpackage

// File: rtl/ea_ctrl.sv
module ea_ctrl
  import ea_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic indirect_i,
  input  logic ptr_valid_i,
  output logic accept_o,
  output logic lo_we_o,
  output logic hi_we_o,
  output logic fetch_o,
  output logic second_o,
  output logic done_o
);
  ea_state_e state_q, state_d;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign fetch_o  = (state_q == ST_PLO) || (state_q == ST_PHI);
  assign second_o = (state_q == ST_PHI);
  assign lo_we_o  = (state_q == ST_PLO) && ptr_valid_i;
  assign hi_we_o  = (state_q == ST_PHI) && ptr_valid_i;
  assign done_o   = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept_o) state_d = indirect_i ? ST_PLO : ST_FIN;
      ST_PLO:  if (ptr_valid_i) state_d = ST_PHI;
      ST_PHI:  if (ptr_valid_i) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/ea_ptr_gen.sv
module ea_ptr_gen
  import ea_pkg::*;
#(
  parameter int DW = 8,
  localparam int AW = 2 * DW
) (
  input  ea_mode_e        mode_i,
  input  logic [DW-1:0]   lo_i,
  input  logic [DW-1:0]   hi_i,
  input  logic [DW-1:0]   x_i,
  input  logic            second_i,
  output logic [AW-1:0]   addr_o,
  output logic            cross_o
);
  logic [DW-1:0] zp_base, zp_loc;
  logic [AW-1:0] abs_base;

  // zero-page pointer: base and +1 both wrap inside page zero
  assign zp_base  = (mode_i == EA_ZP_X_IND) ? lo_i + x_i : lo_i;
  assign zp_loc   = zp_base + {{(DW-1){1'b0}}, second_i};
  assign abs_base = {hi_i, lo_i} + ((mode_i == EA_JMP_X_IND) ? {{DW{1'b0}}, x_i} : '0);
  assign cross_o  = abs_base[AW-1:DW] != hi_i;

  always_comb begin
    if (is_zp_ptr(mode_i)) addr_o = {{DW{1'b0}}, zp_loc};
    else                   addr_o = abs_base + {{(AW-1){1'b0}}, second_i};
  end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] STACK_PAGE = 'h01,
  localparam int AW = 2 * DW
) (
  input  ea_mode_e      mode_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  input  logic          take_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          ptr_cross_i,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] pc_o,
  output logic          pc_load_o,
  output logic          cross_o
);
  logic [AW-1:0] abs_a, sum_x, sum_y, ind_y, br_tgt;

  assign abs_a  = {hi_i, lo_i};
  assign sum_x  = abs_a + {{DW{1'b0}}, x_i};
  assign sum_y  = abs_a + {{DW{1'b0}}, y_i};
  assign ind_y  = ptr_i + {{DW{1'b0}}, y_i};
  assign br_tgt = pc_i + {{DW{lo_i[DW-1]}}, lo_i};

  always_comb begin
    ea_o      = abs_a;
    pc_o      = pc_i;
    pc_load_o = 1'b0;
    cross_o   = 1'b0;
    unique case (mode_i)
      EA_ZP:    ea_o = {{DW{1'b0}}, lo_i};
      EA_ZP_X:  ea_o = {{DW{1'b0}}, lo_i + x_i};
      EA_ZP_Y:  ea_o = {{DW{1'b0}}, lo_i + y_i};
      EA_STACK: ea_o = {STACK_PAGE, sp_i};
      EA_ABS_X: begin
        ea_o    = sum_x;
        cross_o = sum_x[AW-1:DW] != hi_i;
      end
      EA_ABS_Y: begin
        ea_o    = sum_y;
        cross_o = sum_y[AW-1:DW] != hi_i;
      end
      EA_REL: begin
        pc_o      = take_i ? br_tgt : pc_i;
        ea_o      = pc_o;
        pc_load_o = take_i;
        cross_o   = take_i && (br_tgt[AW-1:DW] != pc_i[AW-1:DW]);
      end
      EA_ZP_IND, EA_ZP_X_IND: ea_o = ptr_i;
      EA_ZP_IND_Y: begin
        ea_o    = ind_y;
        cross_o = ind_y[AW-1:DW] != ptr_i[AW-1:DW];
      end
      EA_JMP_IND: begin
        ea_o      = ptr_i;
        pc_o      = ptr_i;
        pc_load_o = 1'b1;
      end
      EA_JMP_X_IND: begin
        ea_o      = ptr_i;
        pc_o      = ptr_i;
        pc_load_o = 1'b1;
        cross_o   = ptr_cross_i;
      end
      default: ea_o = abs_a;
    endcase
  end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
  import ea_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] STACK_PAGE = 'h01,
  localparam int AW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [DW-1:0] op_lo_i,
  input  logic [DW-1:0] op_hi_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  input  logic          take_i,
  input  logic [DW-1:0] ptr_data_i,
  input  logic          ptr_valid_i,
  output logic [AW-1:0] addr_o,
  output logic          ptr_rd_o,
  output logic          done_o,
  output logic [AW-1:0] new_pc_o,
  output logic          pc_load_o,
  output logic          page_cross_o
);
  ea_mode_e      mode_q;
  logic [DW-1:0] lo_q, hi_q, x_q, y_q, sp_q;
  logic [AW-1:0] pc_q, ptr_q;
  logic          take_q;

  logic          accept, lo_we, hi_we, fetch, second, done;
  logic [AW-1:0] ptr_addr, ea, calc_pc;
  logic          ptr_cross, calc_load, calc_cross;

  ea_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .indirect_i  (is_indirect(mode_i)),
    .ptr_valid_i (ptr_valid_i),
    .accept_o    (accept),
    .lo_we_o     (lo_we),
    .hi_we_o     (hi_we),
    .fetch_o     (fetch),
    .second_o    (second),
    .done_o      (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= EA_ABS;
      lo_q   <= '0;
      hi_q   <= '0;
      x_q    <= '0;
      y_q    <= '0;
      sp_q   <= '0;
      pc_q   <= '0;
      take_q <= 1'b0;
      ptr_q  <= '0;
    end else begin
      if (accept) begin
        mode_q <= ea_mode_e'(mode_i);
        lo_q   <= op_lo_i;
        hi_q   <= op_hi_i;
        x_q    <= x_i;
        y_q    <= y_i;
        sp_q   <= sp_i;
        pc_q   <= pc_i;
        take_q <= take_i;
      end
      if (lo_we) ptr_q[DW-1:0]  <= ptr_data_i;
      if (hi_we) ptr_q[AW-1:DW] <= ptr_data_i;
    end
  end

  ea_ptr_gen #(.DW(DW)) u_ptr (
    .mode_i   (mode_q),
    .lo_i     (lo_q),
    .hi_i     (hi_q),
    .x_i      (x_q),
    .second_i (second),
    .addr_o   (ptr_addr),
    .cross_o  (ptr_cross)
  );

  ea_calc #(.DW(DW), .STACK_PAGE(STACK_PAGE)) u_calc (
    .mode_i      (mode_q),
    .lo_i        (lo_q),
    .hi_i        (hi_q),
    .x_i         (x_q),
    .y_i         (y_q),
    .sp_i        (sp_q),
    .pc_i        (pc_q),
    .take_i      (take_q),
    .ptr_i       (ptr_q),
    .ptr_cross_i (ptr_cross),
    .ea_o        (ea),
    .pc_o        (calc_pc),
    .pc_load_o   (calc_load),
    .cross_o     (calc_cross)
  );

  assign addr_o       = fetch ? ptr_addr : ea;
  assign ptr_rd_o     = fetch;
  assign done_o       = done;
  assign new_pc_o     = calc_pc;
  assign pc_load_o    = done && calc_load;
  assign page_cross_o = done && calc_cross;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk
  import ea_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] STACK_PAGE = 'h01,
  localparam int AW = 2 * DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          ptr_valid_i,
  input logic          ptr_rd_o,
  input logic          done_o,
  input logic          pc_load_o,
  input logic          page_cross_o,
  input logic [AW-1:0] addr_o,
  input logic [3:0]    mode_q
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R12

  AST_FETCH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ptr_rd_o && done_o)); // R6

  AST_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_rd_o && !ptr_valid_i) |=> (ptr_rd_o && $stable(addr_o))); // R6

  AST_FETCH_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_rd_o && ptr_valid_i) |=> (ptr_rd_o || done_o)); // R6

  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ptr_rd_o || done_o) && start_i) |=> $stable(mode_q)); // R11

  AST_STACK_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mode_q == EA_STACK) |-> addr_o[AW-1:DW] == STACK_PAGE); // R4

  AST_ZP_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (mode_q == EA_ZP || mode_q == EA_ZP_X || mode_q == EA_ZP_Y))
      |-> addr_o[AW-1:DW] == '0); // R3

  AST_LOAD_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_load_o || page_cross_o) |-> done_o); // R9
endmodule

bind ea_unit ea_unit_chk #(.DW(DW), .STACK_PAGE(STACK_PAGE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .ptr_valid_i  (ptr_valid_i),
  .ptr_rd_o     (ptr_rd_o),
  .done_o       (done_o),
  .pc_load_o    (pc_load_o),
  .page_cross_o (page_cross_o),
  .addr_o       (addr_o),
  .mode_q       (mode_q)
);

// File: tb/sim_ea_unit.sv
`timescale 1ns/1ps
module sim_ea_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [7:0]  op_lo_i = '0, op_hi_i = '0, x_i = '0, y_i = '0, sp_i = '0;
  logic [15:0] pc_i = '0;
  logic        take_i = 1'b0;
  logic [7:0]  ptr_data_i = '0;
  logic        ptr_valid_i = 1'b0;
  logic [15:0] addr_o, new_pc_o;
  logic        ptr_rd_o, done_o, pc_load_o, page_cross_o;

  int total = 0;
  int bad = 0;

  logic [15:0] r_addr, r_pc, pa0, pa1;
  logic        r_load, r_cross;
  int          lat, nfetch;

  always #2.5 clk = ~clk;

  ea_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .mode_i(mode_i),
    .op_lo_i(op_lo_i), .op_hi_i(op_hi_i), .x_i(x_i), .y_i(y_i), .sp_i(sp_i),
    .pc_i(pc_i), .take_i(take_i), .ptr_data_i(ptr_data_i), .ptr_valid_i(ptr_valid_i),
    .addr_o(addr_o), .ptr_rd_o(ptr_rd_o), .done_o(done_o), .new_pc_o(new_pc_o),
    .pc_load_o(pc_load_o), .page_cross_o(page_cross_o)
  );

  function automatic logic [7:0] mem(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] xv, input logic [7:0] yv, input logic [7:0] sv,
                        input logic [15:0] pcv, input logic tk, input bit stall, input bit poke);
    bit stalled;
    stalled = 0;
    @(negedge clk);
    mode_i = m; op_lo_i = lo; op_hi_i = hi; x_i = xv; y_i = yv; sp_i = sv;
    pc_i = pcv; take_i = tk; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1; nfetch = 0; pa0 = '0; pa1 = '0;
    while (!done_o && lat < 12) begin
      if (ptr_rd_o) begin
        if (nfetch == 0) pa0 = addr_o; else pa1 = addr_o;
        if (stall && !stalled) begin
          stalled = 1;
          ptr_valid_i = 1'b0;
          if (poke) begin
            start_i = 1'b1; mode_i = 4'd0; op_lo_i = 8'h00; op_hi_i = 8'h00;
          end
        end else begin
          ptr_data_i = mem(addr_o);
          ptr_valid_i = 1'b1;
          nfetch++;
        end
      end
      @(negedge clk);
      ptr_valid_i = 1'b0;
      start_i = 1'b0;
      lat++;
    end
    r_addr = addr_o; r_pc = new_pc_o; r_load = pc_load_o; r_cross = page_cross_o;
    chk("R12 done asserted", {15'd0, done_o}, 16'd1);
    @(negedge clk);
    chk("R12 done one cycle", {15'd0, done_o}, 16'd0);
  endtask

  task automatic t_reset;
    chk("R1 done", {15'd0, done_o}, 16'd0);
    chk("R1 ptr_rd", {15'd0, ptr_rd_o}, 16'd0);
    chk("R1 pc_load", {15'd0, pc_load_o}, 16'd0);
    chk("R1 page_cross", {15'd0, page_cross_o}, 16'd0);
  endtask

  task automatic t_abs;
    run_op(4'd0, 8'h34, 8'h12, 8'h55, 8'h66, 8'h00, 16'h0, 1'b0, 0, 0);
    chk("R2 addr", r_addr, 16'h1234);
    chk("R2 latency", 16'(lat), 16'd1);
    chk("R2 cross", {15'd0, r_cross}, 16'd0);
  endtask

  task automatic t_zp;
    run_op(4'd1, 8'h80, 8'hAB, 8'h00, 8'h00, 8'h00, 16'h0, 1'b0, 0, 0);
    chk("R3 zp", r_addr, 16'h0080);
    run_op(4'd2, 8'hF0, 8'hAB, 8'h20, 8'h00, 8'h00, 16'h0, 1'b0, 0, 0);
    chk("R3 zp,x wrap", r_addr, 16'h0010);
    run_op(4'd3, 8'hFE, 8'hAB, 8'h00, 8'h03, 8'h00, 16'h0, 1'b0, 0, 0);
    chk("R3 zp,y wrap", r_addr, 16'h0001);
  endtask

  task automatic t_stack;
    run_op(4'd6, 8'h11, 8'h22, 8'h00, 8'h00, 8'hFD, 16'h0, 1'b0, 0, 0);
    chk("R4 stack", r_addr, 16'h01FD);
  endtask

  task automatic t_abs_idx;
    run_op(4'd4, 8'hF0, 8'h12, 8'h20, 8'h00, 8'h00, 16'h0, 1'b0, 0, 0);
    chk("R5 abs,x", r_addr, 16'h1310);
    chk("R5 abs,x cross", {15'd0, r_cross}, 16'd1);
    run_op(4'd5, 8'h00, 8'h12, 8'h00, 8'h05, 8'h00, 16'h0, 1'b0, 0, 0);
    chk("R5 abs,y", r_addr, 16'h1205);
    chk("R5 abs,y no cross", {15'd0, r_cross}, 16'd0);
    run_op(4'd5, 8'hFF, 8'hFF, 8'h00, 8'h02, 8'h00, 16'h0, 1'b0, 0, 0);
    chk("R5 abs,y wrap", r_addr, 16'h0001);
    chk("R5 abs,y wrap cross", {15'd0, r_cross}, 16'd1);
  endtask

  task automatic t_zp_ind;
    run_op(4'd9, 8'hFE, 8'h77, 8'h01, 8'h00, 8'h00, 16'h0, 1'b0, 0, 0);
    chk("R6 ptr lo loc", pa0, 16'h00FF);
    chk("R6 ptr hi loc wrap", pa1, 16'h0000);
    chk("R7 (zp,x) ea", r_addr, {mem(16'h0000), mem(16'h00FF)});
    chk("R6 latency", 16'(lat), 16'd3);
    run_op(4'd8, 8'h40, 8'h77, 8'h09, 8'h09, 8'h00, 16'h0, 1'b0, 0, 0);
    chk("R7 (zp) ptr lo", pa0, 16'h0040);
    chk("R7 (zp) ea", r_addr, {mem(16'h0041), mem(16'h0040)});
  endtask

  task automatic t_ind_y;
    logic [15:0] p, e;
    p = {mem(16'h0000), mem(16'h00FF)};
    e = p + 16'h00FF;
    run_op(4'd10, 8'hFF, 8'h77, 8'h00, 8'hFF, 8'h00, 16'h0, 1'b0, 0, 0);
    chk("R8 ptr hi wrap", pa1, 16'h0000);
    chk("R8 (zp),y ea", r_addr, e);
    chk("R8 cross", {15'd0, r_cross}, {15'd0, e[15:8] != p[15:8]});
    p = {mem(16'h0031), mem(16'h0030)};
    e = p + 16'h0004;
    run_op(4'd10, 8'h30, 8'h77, 8'h00, 8'h04, 8'h00, 16'h0, 1'b0, 1, 1);
    chk("R6 stall latency", 16'(lat), 16'd4);
    chk("R11 ignored start ea", r_addr, e);
    chk("R11 still idle after", {15'd0, ptr_rd_o | done_o}, 16'd0);
  endtask

  task automatic t_jmp;
    run_op(4'd11, 8'hFF, 8'h12, 8'h00, 8'h00, 8'h00, 16'h4000, 1'b0, 0, 0);
    chk("R9 ind lo loc", pa0, 16'h12FF);
    chk("R9 ind hi loc carry", pa1, 16'h1300);
    chk("R9 ind pc", r_pc, {mem(16'h1300), mem(16'h12FF)});
    chk("R9 ind load", {15'd0, r_load}, 16'd1);
    run_op(4'd12, 8'hFE, 8'h20, 8'h03, 8'h00, 8'h00, 16'h4000, 1'b0, 0, 0);
    chk("R9 x-ind lo loc", pa0, 16'h2101);
    chk("R9 x-ind pc", r_pc, {mem(16'h2102), mem(16'h2101)});
    chk("R9 x-ind cross", {15'd0, r_cross}, 16'd1);
  endtask

  task automatic t_rel;
    run_op(4'd7, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1000, 1'b1, 0, 0);
    chk("R10 fwd pc", r_pc, 16'h1010);
    chk("R10 fwd load", {15'd0, r_load}, 16'd1);
    chk("R10 fwd cross", {15'd0, r_cross}, 16'd0);
    run_op(4'd7, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1000, 1'b1, 0, 0);
    chk("R10 back pc", r_pc, 16'h0FF0);
    chk("R10 back cross", {15'd0, r_cross}, 16'd1);
    run_op(4'd7, 8'hF0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h1000, 1'b0, 0, 0);
    chk("R10 not taken pc", r_pc, 16'h1000);
    chk("R10 not taken load", {15'd0, r_load}, 16'd0);
    chk("R10 not taken cross", {15'd0, r_cross}, 16'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_abs();
    t_zp();
    t_stack();
    t_abs_idx();
    t_zp_ind();
    t_ind_y();
    t_jmp();
    t_rel();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule